// File: doc/BRIEF.md
# Partial Peripheral I/O Decoder

This block sits between a small processor's I/O bus and a group of peripherals: a mode/palette controller, a display timing controller, a parallel port, a floppy controller, a disk motor latch and an upper-ROM select latch. Each I/O access arrives as a 16-bit port address with a write, read or interrupt-acknowledge strobe. The block turns it into one-clock registered write strobes and builds the read data the processor sees. A device is selected by one or a few address bits being low, not by a full address compare. One access can therefore reach several devices at once.

Two of the devices latch the bus on read cycles as well as on write cycles. On a read cycle they receive the merged read value, the same byte the processor is handed. A small cycle state machine tracks the bus strobes so that a strobe held for many clocks produces exactly one set of write pulses.

The machine has four states. `CYC_IDLE` waits for a strobe. `CYC_WRITE`, `CYC_READ` and `CYC_ACK` hold while their strobe stays high. The transitions are:
- issue: from idle into a busy state. The acknowledge strobe wins over the write strobe, and the write strobe wins over the read strobe.
- release: from a busy state back to idle, once its strobe drops.

Top module: `io_port_decoder`

## Requirements
- R1: After reset every strobe output and `ack_pulse` are 0, `motor_on` and `rom_alt` are 0, and `wr_bus`, `pio_rs` and `fdc_rs` are 0.
- R2: Every write strobe and `ack_pulse` goes high for exactly one clock. This happens in the clock after the edge that first samples the bus strobe, however long the bus strobe is held.
- R3: When address bits [15:14] are `01`, `mctl_wr` pulses on both write and read cycles. `wr_bus` carries the write data on a write cycle and the merged read value on a read cycle.
- R4: When address bit 14 is 0, address bits [9:8] select the timing-controller function: 0 is index select, 1 is register write, 2 is status read and 3 is register read. `tmg_idx_wr` pulses for function 0 and `tmg_reg_wr` pulses for function 1, on write and read cycles alike. On a read cycle `wr_bus` carries the merged read value.
- R5: On a write cycle with address bit 11 at 0, `pio_wr` pulses and `pio_rs` takes address bits [9:8].
- R6: On a write cycle with address bits {10,8,7} equal to `010`, `fdc_wr` pulses and `fdc_rs` takes address bit 0.
- R7: On a write cycle with address bits 10, 8 and 7 all 0, `motor_on` becomes 1 if the write data is nonzero and 0 if it is zero.
- R8: On a write cycle with address bit 13 at 0, `rom_alt` becomes 1 if the write data equals 7 and 0 for any other value.
- R9: During a read cycle, `rd_data` starts from 0xFF and ANDs in the data of each selected source. The sources are: the parallel port when bit 11 is 0, the floppy controller when bits {10,8,7} are `010`, and the timing controller when bit 14 is 0 with function 2 or 3.
- R10: During an acknowledge cycle, `rd_data` is 0xFF and `ack_pulse` pulses once. No write strobe fires and neither latch changes.
- R11: A single access whose address matches several devices strobes all of them in the same clock.
- R12: A read cycle never pulses `pio_wr` or `fdc_wr` and never changes `motor_on` or `rom_alt`, even when the address matches those devices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data from the processor |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| int_ack | input | 1 | Interrupt acknowledge strobe |
| tmg_rdata | input | 8 | Timing controller read data |
| pio_rdata | input | 8 | Parallel port read data |
| fdc_rdata | input | 8 | Floppy controller read data |
| rd_data | output | 8 | Merged read data |
| mctl_wr | output | 1 | Mode controller write strobe |
| tmg_idx_wr | output | 1 | Timing controller index-select strobe |
| tmg_reg_wr | output | 1 | Timing controller register-write strobe |
| pio_wr | output | 1 | Parallel port write strobe |
| pio_rs | output | 2 | Parallel port register select |
| fdc_wr | output | 1 | Floppy controller write strobe |
| fdc_rs | output | 1 | Floppy controller register select |
| wr_bus | output | 8 | Data accompanying the write strobes |
| motor_on | output | 1 | Disk motor control latch |
| rom_alt | output | 1 | Upper ROM select latch (1 = alternate) |
| ack_pulse | output | 1 | Acknowledge pulse to the interrupt generator |

## Verification
The bench builds the block with its default widths: a 16-bit address, 8-bit data and an alternate-ROM code of 7. These are the values the address bit positions and the latch decodes are defined for. The three read sources are held at distinct patterns, so each AND merge shows in the result, including the case where two sources combine. Addresses are chosen to hit one device, several devices, or devices that act on reads. Strobe lengths of one and four clocks exercise the one-pulse rule.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

    // Address bit positions that carry decode meaning
    localparam int unsigned BIT_MCTL_HI = 15;
    localparam int unsigned BIT_TMG     = 14;
    localparam int unsigned BIT_ROM     = 13;
    localparam int unsigned BIT_PIO     = 11;
    localparam int unsigned BIT_FDC_A   = 10;
    localparam int unsigned BIT_FN_HI   = 9;
    localparam int unsigned BIT_FN_LO   = 8;
    localparam int unsigned BIT_FDC_C   = 7;
    localparam int unsigned BIT_FDC_RS  = 0;

    localparam int unsigned NUM_RD_SRC  = 3;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_WRITE = 2'd1,
        CYC_READ  = 2'd2,
        CYC_ACK   = 2'd3
    } cyc_state_e;

    typedef enum logic [1:0] {
        TFN_INDEX  = 2'd0,
        TFN_WRITE  = 2'd1,
        TFN_STATUS = 2'd2,
        TFN_READ   = 2'd3
    } tmg_fn_e;

    typedef struct packed {
        logic    mctl;
        logic    tmg;
        tmg_fn_e tmg_fn;
        logic    pio;
        logic    fdc;
        logic    motor;
        logic    rom;
    } hit_t;

endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
    import io_dec_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] addr,
    output hit_t          hit
);
    localparam int unsigned FDC_W = 3;

    logic [FDC_W-1:0] fdc_bits;

    always_comb begin
        fdc_bits   = {addr[BIT_FDC_A], addr[BIT_FN_LO], addr[BIT_FDC_C]};
        hit.mctl   = (addr[BIT_MCTL_HI -: 2] == 2'b01);
        hit.tmg    = ~addr[BIT_TMG];
        hit.tmg_fn = tmg_fn_e'(addr[BIT_FN_HI:BIT_FN_LO]);
        hit.pio    = ~addr[BIT_PIO];
        hit.fdc    = (fdc_bits == 3'b010);
        hit.motor  = (fdc_bits == 3'b000);
        hit.rom    = ~addr[BIT_ROM];
    end

endmodule

// File: rtl/io_rd_merge.sv
module io_rd_merge
    import io_dec_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          rd_en,
    input  hit_t          hit,
    input  logic [DW-1:0] tmg_rdata,
    input  logic [DW-1:0] pio_rdata,
    input  logic [DW-1:0] fdc_rdata,
    output logic [DW-1:0] bus
);
    logic [NUM_RD_SRC-1:0]         src_en;
    logic [NUM_RD_SRC-1:0][DW-1:0] src_dat;
    logic [NUM_RD_SRC-1:0][DW-1:0] masked;

    always_comb begin
        src_en[0]  = rd_en & hit.pio;
        src_en[1]  = rd_en & hit.fdc;
        src_en[2]  = rd_en & hit.tmg &
                     ((hit.tmg_fn == TFN_STATUS) || (hit.tmg_fn == TFN_READ));
        src_dat[0] = pio_rdata;
        src_dat[1] = fdc_rdata;
        src_dat[2] = tmg_rdata;
    end

    for (genvar k = 0; k < NUM_RD_SRC; k++) begin : g_src
        assign masked[k] = src_en[k] ? src_dat[k] : {DW{1'b1}};
    end

    always_comb begin
        bus = {DW{1'b1}};
        for (int k = 0; k < NUM_RD_SRC; k++) begin
            bus = bus & masked[k];
        end
    end

endmodule

// File: rtl/io_cycle_fsm.sv
module io_cycle_fsm
    import io_dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_wr,
    input  logic       io_rd,
    input  logic       int_ack,
    output cyc_state_e state,
    output logic       issue_wr,
    output logic       issue_rd,
    output logic       issue_ack
);
    cyc_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CYC_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        issue_wr  = 1'b0;
        issue_rd  = 1'b0;
        issue_ack = 1'b0;
        unique case (state)
            CYC_IDLE: begin
                if (int_ack) begin
                    state_nx  = CYC_ACK;
                    issue_ack = 1'b1;
                end else if (io_wr) begin
                    state_nx = CYC_WRITE;
                    issue_wr = 1'b1;
                end else if (io_rd) begin
                    state_nx = CYC_READ;
                    issue_rd = 1'b1;
                end
            end
            CYC_WRITE: if (!io_wr)   state_nx = CYC_IDLE;
            CYC_READ:  if (!io_rd)   state_nx = CYC_IDLE;
            CYC_ACK:   if (!int_ack) state_nx = CYC_IDLE;
            default:   state_nx = CYC_IDLE;
        endcase
    end

    // R2: an issue only comes from idle, so two issues never follow each other
    a_r2_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_wr || issue_rd || issue_ack) |=> !(issue_wr || issue_rd || issue_ack));

endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
    import io_dec_pkg::*;
#(
    parameter int unsigned AW           = 16,
    parameter int unsigned DW           = 8,
    parameter int unsigned ROM_ALT_CODE = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] io_addr,
    input  logic [DW-1:0] io_wdata,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic          int_ack,
    input  logic [DW-1:0] tmg_rdata,
    input  logic [DW-1:0] pio_rdata,
    input  logic [DW-1:0] fdc_rdata,
    output logic [DW-1:0] rd_data,
    output logic          mctl_wr,
    output logic          tmg_idx_wr,
    output logic          tmg_reg_wr,
    output logic          pio_wr,
    output logic [1:0]    pio_rs,
    output logic          fdc_wr,
    output logic          fdc_rs,
    output logic [DW-1:0] wr_bus,
    output logic          motor_on,
    output logic          rom_alt,
    output logic          ack_pulse
);
    localparam logic [DW-1:0] ROM_CODE = DW'(ROM_ALT_CODE);

    hit_t          hit;
    cyc_state_e    cyc_state;
    logic          issue_wr, issue_rd, issue_ack;
    logic [DW-1:0] merged;
    logic          unused_state;

    assign unused_state = ^cyc_state;

    io_addr_decode #(.AW(AW)) u_dec (
        .addr (io_addr),
        .hit  (hit)
    );

    io_rd_merge #(.DW(DW)) u_merge (
        .rd_en     (io_rd & ~int_ack),
        .hit       (hit),
        .tmg_rdata (tmg_rdata),
        .pio_rdata (pio_rdata),
        .fdc_rdata (fdc_rdata),
        .bus       (merged)
    );

    io_cycle_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .int_ack   (int_ack),
        .state     (cyc_state),
        .issue_wr  (issue_wr),
        .issue_rd  (issue_rd),
        .issue_ack (issue_ack)
    );

    assign rd_data = merged;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mctl_wr    <= 1'b0;
            tmg_idx_wr <= 1'b0;
            tmg_reg_wr <= 1'b0;
            pio_wr     <= 1'b0;
            fdc_wr     <= 1'b0;
            pio_rs     <= '0;
            fdc_rs     <= 1'b0;
            wr_bus     <= '0;
            motor_on   <= 1'b0;
            rom_alt    <= 1'b0;
            ack_pulse  <= 1'b0;
        end else begin
            mctl_wr    <= 1'b0;
            tmg_idx_wr <= 1'b0;
            tmg_reg_wr <= 1'b0;
            pio_wr     <= 1'b0;
            fdc_wr     <= 1'b0;
            ack_pulse  <= issue_ack;
            if (issue_wr || issue_rd) begin
                mctl_wr    <= hit.mctl;
                tmg_idx_wr <= hit.tmg && (hit.tmg_fn == TFN_INDEX);
                tmg_reg_wr <= hit.tmg && (hit.tmg_fn == TFN_WRITE);
                pio_rs     <= io_addr[BIT_FN_HI:BIT_FN_LO];
                fdc_rs     <= io_addr[BIT_FDC_RS];
                wr_bus     <= issue_wr ? io_wdata : merged;
            end
            if (issue_wr) begin
                pio_wr <= hit.pio;
                fdc_wr <= hit.fdc;
                if (hit.motor) motor_on <= |io_wdata;
                if (hit.rom)   rom_alt  <= (io_wdata == ROM_CODE);
            end
        end
    end

    // R2: strobes last one clock
    a_r2_mctl_one: assert property (@(posedge clk) disable iff (!rst_n)
        mctl_wr |=> !mctl_wr);
    a_r2_pio_one: assert property (@(posedge clk) disable iff (!rst_n)
        pio_wr |=> !pio_wr);
    // R10: acknowledge returns all ones and is one clock long
    a_r10_ack_ff: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> (rd_data == {DW{1'b1}}));
    a_r10_ack_one: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |=> !ack_pulse);
    a_r10_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |-> !(mctl_wr || tmg_idx_wr || tmg_reg_wr || pio_wr || fdc_wr));
    // R4: one timing-controller function per access; R3 exclusive by bit 14
    a_r4_tmg_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mctl_wr, tmg_idx_wr, tmg_reg_wr}));
    // R12: latches and read-only-ignored strobes move only after a write
    a_r12_rom_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rom_alt) |-> $past(io_wr));
    a_r12_motor_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(motor_on) |-> $past(io_wr));
    a_r12_fdc_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        fdc_wr |-> $past(io_wr));

endmodule

// File: tb/tb_io_port_decoder.sv
module tb_io_port_decoder;
    localparam int CLK_P = 10;
    localparam int K_WR = 0, K_RD = 1, K_ACK = 2;
    localparam logic [7:0] TMG_V = 8'hA5, PIO_V = 8'h3C, FDC_V = 8'hF0;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic io_wr = 1'b0, io_rd = 1'b0, int_ack = 1'b0;
    logic [7:0] rd_data, wr_bus;
    logic mctl_wr, tmg_idx_wr, tmg_reg_wr, pio_wr, fdc_wr, fdc_rs, motor_on, rom_alt, ack_pulse;
    logic [1:0] pio_rs;

    io_port_decoder dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .int_ack(int_ack),
        .tmg_rdata(TMG_V), .pio_rdata(PIO_V), .fdc_rdata(FDC_V),
        .rd_data(rd_data), .mctl_wr(mctl_wr), .tmg_idx_wr(tmg_idx_wr),
        .tmg_reg_wr(tmg_reg_wr), .pio_wr(pio_wr), .pio_rs(pio_rs),
        .fdc_wr(fdc_wr), .fdc_rs(fdc_rs), .wr_bus(wr_bus),
        .motor_on(motor_on), .rom_alt(rom_alt), .ack_pulse(ack_pulse)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        int          stamp;
        logic [18:0] v;
        string       tag;
    } item_t;

    item_t q[$];
    int cyc = 0, n_chk = 0, n_bad = 0;
    bit done = 0;
    logic       m_motor = 0, m_rom = 0, m_fdc_rs = 0;
    logic [1:0] m_pio_rs = 0;
    logic [7:0] m_bus = 0;

    function automatic logic [18:0] outs();
        return {mctl_wr, tmg_idx_wr, tmg_reg_wr, pio_wr, fdc_wr, ack_pulse,
                pio_rs, fdc_rs, wr_bus, motor_on, rom_alt};
    endfunction

    task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R9: merged read value computed from the requirement text
    function automatic logic [7:0] rd_model(input logic [15:0] a);
        logic [7:0] r = 8'hFF;
        if (!a[11]) r &= PIO_V;
        if ({a[10], a[8], a[7]} == 3'b010) r &= FDC_V;
        if (!a[14] && a[9]) r &= TMG_V;
        return r;
    endfunction

    task automatic run_cyc(input int kind, input logic [15:0] a, input logic [7:0] d,
                           input int hold, input string tag);
        logic mc, ti, tr, pw, fw, ak;
        logic [7:0] rv;
        item_t it;
        @(negedge clk);
        io_addr = a; io_wdata = d;
        io_wr = (kind == K_WR); io_rd = (kind == K_RD); int_ack = (kind == K_ACK);
        rv = (kind == K_RD) ? rd_model(a) : 8'hFF;
        mc = 0; ti = 0; tr = 0; pw = 0; fw = 0; ak = (kind == K_ACK);
        if (kind != K_ACK) begin
            mc = (a[15:14] == 2'b01);                      // R3
            ti = !a[14] && (a[9:8] == 2'd0);               // R4
            tr = !a[14] && (a[9:8] == 2'd1);               // R4
            m_pio_rs = a[9:8]; m_fdc_rs = a[0];
            m_bus = (kind == K_WR) ? d : rv;
        end
        if (kind == K_WR) begin
            pw = !a[11];                                   // R5
            fw = ({a[10], a[8], a[7]} == 3'b010);          // R6
            if ({a[10], a[8], a[7]} == 3'b000) m_motor = (d != 0); // R7
            if (!a[13]) m_rom = (d == 8'd7);               // R8
        end
        it.stamp = cyc + 1;
        it.v = {mc, ti, tr, pw, fw, ak, m_pio_rs, m_fdc_rs, m_bus, m_motor, m_rom};
        it.tag = tag;
        q.push_back(it);
        it.stamp = cyc + 2;
        it.v = {6'b0, m_pio_rs, m_fdc_rs, m_bus, m_motor, m_rom};
        it.tag = "R2 strobe drop";
        q.push_back(it);
        #1;
        if (kind != K_WR)
            check((kind == K_ACK) ? "R10 rd_data" : "R9 rd_data",
                  {11'b0, rd_data}, {11'b0, rv});
        repeat (hold) @(negedge clk);
        io_wr = 0; io_rd = 0; int_ack = 0;
        @(negedge clk);
    endtask

    // monitor: compares the scoreboard against the outputs
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            cyc++;
            while (q.size() > 0 && q[0].stamp <= cyc) begin
                check(q[0].tag, outs(), q[0].v);
                void'(q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", outs(), 19'b0);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", outs(), 19'b0);
        run_cyc(K_WR, 16'h7F00, 8'h8C, 1, "R3 mode ctl write");
        run_cyc(K_WR, 16'hBC00, 8'h0C, 1, "R4 index select");
        run_cyc(K_WR, 16'hBD00, 8'h30, 1, "R4 register write");
        run_cyc(K_WR, 16'hF782, 8'h82, 1, "R5 pio write rs3");
        run_cyc(K_WR, 16'hFB7F, 8'h55, 1, "R6 fdc write rs1");
        run_cyc(K_WR, 16'hFA7E, 8'h01, 1, "R7 motor on");
        run_cyc(K_WR, 16'hFA7E, 8'h00, 1, "R7 motor off");
        run_cyc(K_WR, 16'hDF00, 8'h07, 1, "R8 rom alternate");
        run_cyc(K_WR, 16'hDF00, 8'h03, 1, "R8 rom default");
        run_cyc(K_WR, 16'h0000, 8'h07, 1, "R11 multi-hit write");
        run_cyc(K_WR, 16'h7F00, 8'h11, 4, "R2 long write strobe");
        run_cyc(K_RD, 16'hF500, 8'h00, 1, "R9 pio read");
        run_cyc(K_RD, 16'hBE00, 8'h00, 1, "R9 timing status read");
        run_cyc(K_RD, 16'h3F00, 8'h00, 1, "R9 timing register read");
        run_cyc(K_RD, 16'hFB7E, 8'h00, 1, "R9 fdc read");
        run_cyc(K_RD, 16'hBC00, 8'h00, 1, "R4 read acts as index select");
        run_cyc(K_RD, 16'h4000, 8'h00, 1, "R3 R12 read latches mode ctl");
        run_cyc(K_RD, 16'h0100, 8'h00, 3, "R11 R12 multi-hit read");
        run_cyc(K_WR, 16'hFA7E, 8'h09, 1, "R7 motor on again");
        run_cyc(K_RD, 16'h0000, 8'h00, 1, "R12 read keeps latches");
        run_cyc(K_ACK, 16'h0000, 8'h00, 2, "R10 acknowledge");
        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R2 scoreboard left %0d expected items", q.size());
        end
        finish_run();
    end

endmodule